// File: doc/BRIEF.md
# Single-Bus Instruction Step Sequencer

This block is the control unit for a 32-bit processor whose registers all share one bus. A step counter walks through numbered time steps. In each step the block asserts gate lines, which choose the one source that drives the bus, and strobe lines, which choose the registers that capture the bus or the ALU result at the clock edge that closes the step. Steps 0 to 2 fetch the next instruction. From step 3 onward, the opcode field of the instruction register selects the sequence for add, add-immediate, load, store, conditional branch or shift-right.

Memory is coupled through a read, write and done handshake. The counter holds a waiting step until memory reports done. It can repeat step 6 while the shift counter is nonzero. When the end line is asserted, it returns to step 0. The datapath registers, the ALU, sign extension, the zero base for register 0 and the memory itself are outside the block. The sequencer only names which of them act in each step.

Top module: `seq_bus_ctrl`

## Requirements
- R1: A high `rst` at a rising edge puts the step counter at 0, whatever step was running. At step 0 the fetch outputs of R2 appear.
- R2: Steps 0 to 2 ignore `op`. Step 0 gates the PC (gate bit 0), strobes MA (strobe bit 0) and C (strobe bit 5), and selects ALU increment-by-4 (alu bit 0). Step 1 raises `mem_rd`, gates C (gate bit 1) and strobes PC (strobe bit 1). Step 2 gates MD (gate bit 2) and strobes IR (strobe bit 3).
- R3: In step 1, and in step 6 of a load, the counter holds while `mem_done` is low. Strobe bit 8 (MD loads from memory) is high in those steps only while `mem_done` is high.
- R4: In steps without a memory wait, the counter advances by one per clock. When `seq_end` is high and the step is not waiting, the next step is 0.
- R5: Opcode 12 (add) runs the following steps. Step 3: select rb (sel bit 1), gate register (gate bit 3), strobe A (strobe bit 4). Step 4: select rc (sel bit 2), gate register, ALU add (alu bit 1), strobe C. Step 5: gate C, select ra (sel bit 0), strobe the register file (strobe bit 6), end.
- R6: Opcode 13 (add-immediate) matches add, except that step 4 gates the sign-extended 17-bit constant (gate bit 5) and selects no register.
- R7: Load (opcode 1) and store (opcode 3) share their address steps. Step 3: select rb, gate base-or-zero (gate bit 4), strobe A. Step 4: gate constant, ALU add, strobe C. Step 5: gate C, strobe MA.
- R8: Load step 6 raises `mem_rd` and waits. Load step 7 gates MD, selects ra, strobes the register file and ends.
- R9: Store step 6 selects ra, gates register, strobes MD from the bus (strobe bit 7) and raises `mem_wr`. Store step 7 keeps `mem_wr` and `seq_end` high and waits for `mem_done`.
- R10: Opcode 8 (branch) step 3 selects rc, gates register and strobes the condition bit (strobe bit 9). Step 4 selects rb, gates register, strobes PC only if the condition holds (strobe bit 2) and ends.
- R11: Opcode 26 (shift-right) runs the following steps. Step 3: gate the 5-bit count constant (gate bit 6) and load the counter (strobe bit 10). Step 4: if `cnt_zero`, select rc, gate register and reload the counter. Step 5: select rb, gate register, ALU pass (alu bit 2), strobe C. Step 6: while `cnt_zero` is low, gate C, ALU shift (alu bit 3), strobe C, decrement (strobe bit 11) and repeat step 6. Step 7: gate C, select ra, strobe the register file, end.
- R12: Any other opcode asserts `seq_end` alone at step 3, with no gate, strobe or memory line.
- R13: At most one gate bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | OPW (5) | Opcode field of the instruction register |
| mem_done | input | 1 | Memory finished the current read or write |
| cnt_zero | input | 1 | Shift counter equals zero |
| step | output | clog2(STEPS) (3) | Current time step |
| gate | output | 7 | Bus source selects: PC, C, MD, register, base-or-zero, long constant, count constant |
| sel | output | 3 | Register field select: ra, rb, rc |
| strobe | output | 12 | Register loads: MA, PC, PC-if-cond, IR, A, C, register file, MD-bus, MD-memory, condition, count load, count decrement |
| alu_fn | output | 4 | ALU function: increment-by-4, add, pass, shift right |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| seq_end | output | 1 | Last step of the instruction |

## Verification
A table of cycles runs every opcode through fetch and execution. The opcode is set before step 3, so a mix-up between sequences that differ in one step shows up: add against add-immediate at step 4, load against store from step 6 on. Memory-done is driven low at fetch, at the load read and at the store write. This separates a waiting step from one that must not wait, such as add step 3 with done low. The shift-right runs two ways. In one, the constant is zero, so the count is reloaded from a register and step 6 repeats twice. In the other, the constant is nonzero and no reload happens. An unknown opcode, a long fetch stall and a reset in the middle of an instruction finish the set.

// File: rtl/seqb_pkg.sv
package seqb_pkg;
   // gate bit positions (bus source)
   localparam int G_PC   = 0;
   localparam int G_C    = 1;
   localparam int G_MD   = 2;
   localparam int G_REG  = 3;
   localparam int G_BASE = 4;
   localparam int G_K2   = 5;
   localparam int G_K1   = 6;
   localparam int NGATE  = 7;
   // register field selects
   localparam int F_RA = 0;
   localparam int F_RB = 1;
   localparam int F_RC = 2;
   localparam int NSEL = 3;
   // strobe bit positions
   localparam int S_MA    = 0;
   localparam int S_PC    = 1;
   localparam int S_PCC   = 2;
   localparam int S_IR    = 3;
   localparam int S_A     = 4;
   localparam int S_C     = 5;
   localparam int S_REG   = 6;
   localparam int S_MDB   = 7;
   localparam int S_MDM   = 8;
   localparam int S_COND  = 9;
   localparam int S_CLD   = 10;
   localparam int S_CDEC  = 11;
   localparam int NSTRB   = 12;
   // ALU function bits
   localparam int A_INC4 = 0;
   localparam int A_ADD  = 1;
   localparam int A_PASS = 2;
   localparam int A_SHR  = 3;
   localparam int NALU   = 4;

   typedef struct packed {
      logic [NGATE-1:0] gate;
      logic [NSEL-1:0]  sel;
      logic [NSTRB-1:0] strb;
      logic [NALU-1:0]  alu;
      logic             rd;
      logic             wr;
      logic             fin;
      logic             wait_mem;
      logic             hold;
   } ctl_t;
endpackage

// File: rtl/seqb_step_ctr.sv
module seqb_step_ctr #(
   parameter int STEPS   = 8,
   parameter bit ONE_HOT = 1'b0,
   localparam int SW     = $clog2(STEPS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic          fin,
   input  logic          loop,
   output logic [SW-1:0] step
);
   generate
      if (ONE_HOT) begin : g_onehot
         logic [STEPS-1:0] oh;
         always_ff @(posedge clk) begin
            if (rst)
               oh <= STEPS'(1);
            else if (adv) begin
               if (fin)
                  oh <= STEPS'(1);
               else if (!loop)
                  oh <= oh << 1;
            end
         end
         always_comb begin
            step = '0;
            for (int i = 0; i < STEPS; i++)
               if (oh[i]) step = step | SW'(i);
         end
      end else begin : g_binary
         logic [SW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst)
               cnt <= '0;
            else if (adv) begin
               if (fin)
                  cnt <= '0;
               else if (!loop)
                  cnt <= cnt + SW'(1);
            end
         end
         assign step = cnt;
      end
   endgenerate
endmodule

// File: rtl/seqb_decode.sv
module seqb_decode
   import seqb_pkg::*;
#(
   parameter int STEPS = 8,
   parameter int OPW   = 5,
   parameter logic [OPW-1:0] OP_LD   = OPW'(1),
   parameter logic [OPW-1:0] OP_ST   = OPW'(3),
   parameter logic [OPW-1:0] OP_BR   = OPW'(8),
   parameter logic [OPW-1:0] OP_ADD  = OPW'(12),
   parameter logic [OPW-1:0] OP_ADDI = OPW'(13),
   parameter logic [OPW-1:0] OP_SHR  = OPW'(26),
   localparam int SW = $clog2(STEPS)
) (
   input  logic [SW-1:0]  step,
   input  logic [OPW-1:0] op,
   input  logic           cnt_zero,
   input  logic           mem_done,
   output ctl_t           ctl
);
   always_comb begin
      ctl = '0;
      case (int'(step))
         0: begin
            ctl.gate[G_PC] = 1'b1;
            ctl.strb[S_MA] = 1'b1;
            ctl.strb[S_C]  = 1'b1;
            ctl.alu[A_INC4] = 1'b1;
         end
         1: begin
            ctl.rd = 1'b1;
            ctl.wait_mem = 1'b1;
            ctl.gate[G_C] = 1'b1;
            ctl.strb[S_PC] = 1'b1;
            ctl.strb[S_MDM] = mem_done;
         end
         2: begin
            ctl.gate[G_MD] = 1'b1;
            ctl.strb[S_IR] = 1'b1;
         end
         3: begin
            case (op)
               OP_ADD, OP_ADDI: begin
                  ctl.sel[F_RB] = 1'b1;
                  ctl.gate[G_REG] = 1'b1;
                  ctl.strb[S_A] = 1'b1;
               end
               OP_LD, OP_ST: begin
                  ctl.sel[F_RB] = 1'b1;
                  ctl.gate[G_BASE] = 1'b1;
                  ctl.strb[S_A] = 1'b1;
               end
               OP_BR: begin
                  ctl.sel[F_RC] = 1'b1;
                  ctl.gate[G_REG] = 1'b1;
                  ctl.strb[S_COND] = 1'b1;
               end
               OP_SHR: begin
                  ctl.gate[G_K1] = 1'b1;
                  ctl.strb[S_CLD] = 1'b1;
               end
               default: ctl.fin = 1'b1;
            endcase
         end
         4: begin
            case (op)
               OP_ADD: begin
                  ctl.sel[F_RC] = 1'b1;
                  ctl.gate[G_REG] = 1'b1;
                  ctl.alu[A_ADD] = 1'b1;
                  ctl.strb[S_C] = 1'b1;
               end
               OP_ADDI, OP_LD, OP_ST: begin
                  ctl.gate[G_K2] = 1'b1;
                  ctl.alu[A_ADD] = 1'b1;
                  ctl.strb[S_C] = 1'b1;
               end
               OP_BR: begin
                  ctl.sel[F_RB] = 1'b1;
                  ctl.gate[G_REG] = 1'b1;
                  ctl.strb[S_PCC] = 1'b1;
                  ctl.fin = 1'b1;
               end
               OP_SHR: begin
                  ctl.sel[F_RC] = cnt_zero;
                  ctl.gate[G_REG] = cnt_zero;
                  ctl.strb[S_CLD] = cnt_zero;
               end
               default: ;
            endcase
         end
         5: begin
            case (op)
               OP_ADD, OP_ADDI: begin
                  ctl.gate[G_C] = 1'b1;
                  ctl.sel[F_RA] = 1'b1;
                  ctl.strb[S_REG] = 1'b1;
                  ctl.fin = 1'b1;
               end
               OP_LD, OP_ST: begin
                  ctl.gate[G_C] = 1'b1;
                  ctl.strb[S_MA] = 1'b1;
               end
               OP_SHR: begin
                  ctl.sel[F_RB] = 1'b1;
                  ctl.gate[G_REG] = 1'b1;
                  ctl.alu[A_PASS] = 1'b1;
                  ctl.strb[S_C] = 1'b1;
               end
               default: ;
            endcase
         end
         6: begin
            case (op)
               OP_LD: begin
                  ctl.rd = 1'b1;
                  ctl.wait_mem = 1'b1;
                  ctl.strb[S_MDM] = mem_done;
               end
               OP_ST: begin
                  ctl.sel[F_RA] = 1'b1;
                  ctl.gate[G_REG] = 1'b1;
                  ctl.strb[S_MDB] = 1'b1;
                  ctl.wr = 1'b1;
               end
               OP_SHR: begin
                  ctl.gate[G_C] = !cnt_zero;
                  ctl.alu[A_SHR] = !cnt_zero;
                  ctl.strb[S_C] = !cnt_zero;
                  ctl.strb[S_CDEC] = !cnt_zero;
                  ctl.hold = !cnt_zero;
               end
               default: ;
            endcase
         end
         7: begin
            case (op)
               OP_LD, OP_SHR: begin
                  ctl.gate[op == OP_LD ? G_MD : G_C] = 1'b1;
                  ctl.sel[F_RA] = 1'b1;
                  ctl.strb[S_REG] = 1'b1;
                  ctl.fin = 1'b1;
               end
               OP_ST: begin
                  ctl.wr = 1'b1;
                  ctl.wait_mem = 1'b1;
                  ctl.fin = 1'b1;
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/seq_bus_ctrl.sv
module seq_bus_ctrl
   import seqb_pkg::*;
#(
   parameter int STEPS   = 8,
   parameter int OPW     = 5,
   parameter bit ONE_HOT = 1'b0,
   localparam int SW     = $clog2(STEPS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OPW-1:0]    op,
   input  logic              mem_done,
   input  logic              cnt_zero,
   output logic [SW-1:0]     step,
   output logic [NGATE-1:0]  gate,
   output logic [NSEL-1:0]   sel,
   output logic [NSTRB-1:0]  strobe,
   output logic [NALU-1:0]   alu_fn,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              seq_end
);
   generate
      if (STEPS != 8) begin : g_bad_steps
         $error("seq_bus_ctrl: STEPS must be 8");
      end
      if (OPW < 5) begin : g_bad_opw
         $error("seq_bus_ctrl: OPW must hold opcode 26");
      end
   endgenerate

   ctl_t ctl;
   logic adv;

   seqb_decode #(.STEPS(STEPS), .OPW(OPW)) i_dec (
      .step(step), .op(op), .cnt_zero(cnt_zero), .mem_done(mem_done), .ctl(ctl)
   );

   assign adv = !ctl.wait_mem || mem_done;

   seqb_step_ctr #(.STEPS(STEPS), .ONE_HOT(ONE_HOT)) i_ctr (
      .clk(clk), .rst(rst), .adv(adv), .fin(ctl.fin), .loop(ctl.hold), .step(step)
   );

   assign gate    = ctl.gate;
   assign sel     = ctl.sel;
   assign strobe  = ctl.strb;
   assign alu_fn  = ctl.alu;
   assign mem_rd  = ctl.rd;
   assign mem_wr  = ctl.wr;
   assign seq_end = ctl.fin;
endmodule

// File: rtl/seqb_checks.sv
module seqb_checks
   import seqb_pkg::*;
#(
   parameter int STEPS = 8,
   localparam int SW   = $clog2(STEPS)
) (
   input logic             clk,
   input logic             rst,
   input logic [SW-1:0]    step,
   input logic             mem_done,
   input logic [NGATE-1:0] gate,
   input logic [NSTRB-1:0] strobe,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             seq_end
);
   assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> step == '0);

   assert_fetch_stall_R3: assert property (@(posedge clk) disable iff (rst)
      (step == SW'(1) && !mem_done) |=> step == SW'(1));

   assert_end_plain_R4: assert property (@(posedge clk) disable iff (rst)
      (seq_end && !mem_wr) |=> step == '0);

   assert_end_done_R4: assert property (@(posedge clk) disable iff (rst)
      (seq_end && mem_done) |=> step == '0);

   assert_rw_apart_R9: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   assert_shift_repeat_R11: assert property (@(posedge clk) disable iff (rst)
      strobe[S_CDEC] |=> step == SW'(6));

   assert_one_source_R13: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gate));
endmodule

bind seq_bus_ctrl seqb_checks #(.STEPS(STEPS)) i_chk (
   .clk(clk), .rst(rst), .step(step), .mem_done(mem_done), .gate(gate),
   .strobe(strobe), .mem_rd(mem_rd), .mem_wr(mem_wr), .seq_end(seq_end)
);

// File: tb/test_seq_bus_ctrl.sv
module test_seq_bus_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] op = 5'd0;
   logic       mem_done = 1'b1;
   logic       cnt_zero = 1'b1;
   logic [2:0] step;
   logic [6:0] gate;
   logic [2:0] sel;
   logic [11:0] strobe;
   logic [3:0] alu_fn;
   logic       mem_rd, mem_wr, seq_end;
   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   seq_bus_ctrl i_seq_bus_ctrl (
      .clk(clk), .rst(rst), .op(op), .mem_done(mem_done), .cnt_zero(cnt_zero),
      .step(step), .gate(gate), .sel(sel), .strobe(strobe), .alu_fn(alu_fn),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .seq_end(seq_end)
   );

   // vector: {opcode, cnt_zero, mem_done, expected step}
   localparam int NV = 60;
   localparam logic [9:0] VEC [0:NV-1] = '{
      {5'd12,1'b1,1'b1,3'd0}, {5'd12,1'b1,1'b0,3'd1}, {5'd12,1'b1,1'b1,3'd1},
      {5'd12,1'b1,1'b1,3'd2}, {5'd12,1'b1,1'b0,3'd3}, {5'd12,1'b1,1'b1,3'd4},
      {5'd12,1'b1,1'b1,3'd5},
      {5'd13,1'b1,1'b1,3'd0}, {5'd13,1'b1,1'b1,3'd1}, {5'd13,1'b1,1'b1,3'd2},
      {5'd13,1'b1,1'b1,3'd3}, {5'd13,1'b1,1'b1,3'd4}, {5'd13,1'b1,1'b1,3'd5},
      {5'd1,1'b1,1'b1,3'd0}, {5'd1,1'b1,1'b1,3'd1}, {5'd1,1'b1,1'b1,3'd2},
      {5'd1,1'b1,1'b1,3'd3}, {5'd1,1'b1,1'b1,3'd4}, {5'd1,1'b1,1'b1,3'd5},
      {5'd1,1'b1,1'b0,3'd6}, {5'd1,1'b1,1'b1,3'd6}, {5'd1,1'b1,1'b1,3'd7},
      {5'd3,1'b1,1'b1,3'd0}, {5'd3,1'b1,1'b1,3'd1}, {5'd3,1'b1,1'b1,3'd2},
      {5'd3,1'b1,1'b1,3'd3}, {5'd3,1'b1,1'b1,3'd4}, {5'd3,1'b1,1'b1,3'd5},
      {5'd3,1'b1,1'b1,3'd6}, {5'd3,1'b1,1'b0,3'd7}, {5'd3,1'b1,1'b0,3'd7},
      {5'd3,1'b1,1'b1,3'd7},
      {5'd8,1'b1,1'b1,3'd0}, {5'd8,1'b1,1'b1,3'd1}, {5'd8,1'b1,1'b1,3'd2},
      {5'd8,1'b1,1'b1,3'd3}, {5'd8,1'b1,1'b1,3'd4},
      {5'd26,1'b1,1'b1,3'd0}, {5'd26,1'b1,1'b1,3'd1}, {5'd26,1'b1,1'b1,3'd2},
      {5'd26,1'b1,1'b1,3'd3}, {5'd26,1'b1,1'b1,3'd4}, {5'd26,1'b0,1'b1,3'd5},
      {5'd26,1'b0,1'b1,3'd6}, {5'd26,1'b0,1'b1,3'd6}, {5'd26,1'b1,1'b1,3'd6},
      {5'd26,1'b1,1'b1,3'd7},
      {5'd26,1'b1,1'b1,3'd0}, {5'd26,1'b1,1'b1,3'd1}, {5'd26,1'b1,1'b1,3'd2},
      {5'd26,1'b0,1'b1,3'd3}, {5'd26,1'b0,1'b1,3'd4}, {5'd26,1'b1,1'b1,3'd5},
      {5'd26,1'b1,1'b1,3'd6}, {5'd26,1'b1,1'b1,3'd7},
      {5'd31,1'b1,1'b1,3'd0}, {5'd31,1'b1,1'b1,3'd1}, {5'd31,1'b1,1'b1,3'd2},
      {5'd31,1'b1,1'b1,3'd3},
      {5'd12,1'b1,1'b1,3'd0}
   };

   // expected word {gate[6:0], sel[2:0], strobe[11:0], alu[3:0], rd, wr, end}
   function automatic logic [28:0] expect_word(int s, logic [4:0] o, logic cz, logic dn);
      logic [6:0] g; logic [2:0] f; logic [11:0] k; logic [3:0] a;
      logic r, w, e;
      g = '0; f = '0; k = '0; a = '0; r = 0; w = 0; e = 0;
      if (s == 0) begin g = 7'h01; k = 12'h021; a = 4'h1; end
      else if (s == 1) begin g = 7'h02; k = {3'b000, dn, 8'h02}; r = 1; end
      else if (s == 2) begin g = 7'h04; k = 12'h008; end
      else if (o == 5'd12 || o == 5'd13) begin
         if (s == 3) begin f = 3'b010; g = 7'h08; k = 12'h010; end
         if (s == 4) begin f = (o == 5'd12) ? 3'b100 : 3'b000;
                           g = (o == 5'd12) ? 7'h08 : 7'h20; a = 4'h2; k = 12'h020; end
         if (s == 5) begin g = 7'h02; f = 3'b001; k = 12'h040; e = 1; end
      end else if (o == 5'd1 || o == 5'd3) begin
         if (s == 3) begin f = 3'b010; g = 7'h10; k = 12'h010; end
         if (s == 4) begin g = 7'h20; a = 4'h2; k = 12'h020; end
         if (s == 5) begin g = 7'h02; k = 12'h001; end
         if (s == 6 && o == 5'd1) begin r = 1; k = {3'b000, dn, 8'h00}; end
         if (s == 6 && o == 5'd3) begin f = 3'b001; g = 7'h08; k = 12'h080; w = 1; end
         if (s == 7 && o == 5'd1) begin g = 7'h04; f = 3'b001; k = 12'h040; e = 1; end
         if (s == 7 && o == 5'd3) begin w = 1; e = 1; end
      end else if (o == 5'd8) begin
         if (s == 3) begin f = 3'b100; g = 7'h08; k = 12'h200; end
         if (s == 4) begin f = 3'b010; g = 7'h08; k = 12'h004; e = 1; end
      end else if (o == 5'd26) begin
         if (s == 3) begin g = 7'h40; k = 12'h400; end
         if (s == 4 && cz) begin f = 3'b100; g = 7'h08; k = 12'h400; end
         if (s == 5) begin f = 3'b010; g = 7'h08; a = 4'h4; k = 12'h020; end
         if (s == 6 && !cz) begin g = 7'h02; a = 4'h8; k = 12'h820; end
         if (s == 7) begin g = 7'h02; f = 3'b001; k = 12'h040; e = 1; end
      end else if (s == 3) e = 1;
      return {g, f, k, a, r, w, e};
   endfunction

   function automatic string req_tag(int s, logic [4:0] o);
      if (s == 1) return "R3";
      if (s < 3) return "R2";
      case (o)
         5'd12: return "R5";
         5'd13: return "R6";
         5'd1:  return (s < 6) ? "R7" : "R8";
         5'd3:  return (s < 6) ? "R7" : "R9";
         5'd8:  return "R10";
         5'd26: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [28:0] dut_word();
      return {gate, sel, strobe, alu_fn, mem_rd, mem_wr, seq_end};
   endfunction

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 step after reset", 32'(step), 32'd0);
      check("R1 outputs after reset", 32'(dut_word()), 32'(expect_word(0, op, cnt_zero, mem_done)));
      for (int i = 0; i < NV; i++) begin
         op = VEC[i][9:5];
         cnt_zero = VEC[i][4];
         mem_done = VEC[i][3];
         #1;
         check("R4 step sequence", 32'(step), 32'(VEC[i][2:0]));
         check(req_tag(int'(VEC[i][2:0]), VEC[i][9:5]), 32'(dut_word()),
               32'(expect_word(int'(VEC[i][2:0]), VEC[i][9:5], VEC[i][4], VEC[i][3])));
         check("R13 single gate", 32'($countones(gate) <= 1), 32'd1);
         @(negedge clk);
      end
      // long fetch stall (R3)
      mem_done = 1'b0;
      for (int i = 0; i < 5; i++) begin
         #1;
         check("R3 fetch held", 32'(step), 32'd1);
         @(negedge clk);
      end
      mem_done = 1'b1;
      #1;
      check("R3 fetch released", 32'(strobe[8]), 32'd1);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      #1;
      check("R5 mid add step", 32'(step), 32'd4);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 reset mid instruction", 32'(step), 32'd0);
      check("R1 fetch outputs", 32'(dut_word()), 32'(expect_word(0, op, 1'b1, 1'b1)));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule